// File: doc/BRIEF.md
# Ethernet transmit frame replay adapter

This block sits between a packet source and the transmit client port of an Ethernet MAC. The source writes one frame, byte by byte, into a local buffer. A start marker opens the frame and an end marker closes it. Once the frame is closed, the adapter offers its first byte to the MAC with a valid flag and holds it there until the MAC acknowledges. From the next clock on, it streams the remaining bytes with no gaps.

In half-duplex operation the MAC may report a collision while a frame is in flight, and the adapter abandons the frame at once. If the MAC also asks for a retransmission in the same cycle, the adapter offers the buffered frame again from its first byte and waits for a fresh acknowledge. A collision without that request discards the frame. In full-duplex operation the collision and retransmit inputs are ignored.

The buffer holds a single frame. The source is held off for as long as that frame is unsent. Bytes beyond the buffer depth are dropped, and the frame is flagged as truncated.

Top module: `eth_tx_replay_adapter`

## Requirements
- R1: After reset, src_ready is 1, mac_valid is 0, and frame_sent, frame_dropped and frame_truncated are 0.
- R2: While src_ready is 1, a write with src_sof opens a frame at byte 0, and later writes without src_sof append to it. In the cycle after the edge that accepts the write carrying src_eof, mac_valid is 1 and mac_data is byte 0. src_ready is 0 for as long as a frame is held, and writes made while src_ready is 0 change neither the held frame nor any output.
- R3: While mac_valid is 1 and the first byte has not been acknowledged, mac_valid and mac_data stay stable for any number of cycles, as long as no collision is taken into account.
- R4: In the cycle after the edge on which mac_ack is 1 with byte 0 presented, the adapter presents byte 1. It then presents one further byte on every cycle, in order, with mac_valid held at 1. In the cycle after the last byte, mac_valid is 0, src_ready is 1 and frame_sent is 1 for that one cycle only. A one-byte frame finishes in the cycle after its acknowledge.
- R5: When full_duplex is 0, mac_valid is 1, and mac_collision and mac_retransmit are both 1 on an edge, the next cycle shows byte 0 with mac_valid set. The adapter then waits for a new acknowledge and replays the whole frame as in R3 and R4.
- R6: When full_duplex is 0, mac_valid is 1, and mac_collision is 1 with mac_retransmit at 0 on an edge, the next cycle shows mac_valid at 0, src_ready at 1, and frame_dropped at 1 for one cycle only.
- R7: When full_duplex is 1, mac_collision and mac_retransmit have no effect. The frame streams to its end and frame_dropped stays 0.
- R8: Bytes written after MAX_BYTES bytes of a frame are discarded, and the frame then holds its first MAX_BYTES bytes. frame_truncated is 1 in the first cycle in which such a frame is presented and 0 for frames that fit.
- R9: A write with src_sof inside an open frame discards the partial frame and starts a new one. A write without src_sof while no frame is open is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_duplex | input | 1 | 1: collision and retransmit are ignored |
| src_data | input | DATA_W | Source byte |
| src_wr | input | 1 | Source write strobe |
| src_sof | input | 1 | This byte is the first of a frame |
| src_eof | input | 1 | This byte is the last of a frame |
| src_ready | output | 1 | The adapter accepts source writes |
| mac_data | output | DATA_W | Byte offered to the MAC |
| mac_valid | output | 1 | mac_data is part of a frame in flight |
| mac_ack | input | 1 | The MAC accepts the first byte |
| mac_collision | input | 1 | The MAC reports a collision |
| mac_retransmit | input | 1 | The MAC requests a replay, together with the collision |
| frame_sent | output | 1 | One-cycle pulse: the frame was fully streamed |
| frame_dropped | output | 1 | One-cycle pulse: the frame was discarded after a collision |
| frame_truncated | output | 1 | One-cycle pulse: the presented frame was cut to MAX_BYTES |

## Verification
A read pointer that has gone wrong shows up at once on mac_data. The bench compares every streamed byte in every cycle, so a skipped, repeated or stale byte is seen on the first wrong cycle. A wrong state shows either as mac_valid at the wrong level, or as src_ready high while a frame is held. A frame length that has gone wrong shows up only at the end of the frame, as frame_sent arriving one or more cycles off. A replay pointer that was not reset shows in the first cycle after the collision, as a byte other than byte 0.

// File: rtl/eth_tx_replay_pkg.sv
package eth_tx_replay_pkg;
   typedef enum logic [1:0] {
      TXS_FILL   = 2'd0,
      TXS_ARM    = 2'd1,
      TXS_STREAM = 2'd2
   } txs_e;
endpackage

// File: rtl/eth_tx_frame_store.sv
module eth_tx_frame_store #(
   parameter int DATA_W    = 8,
   parameter int MAX_BYTES = 1518,
   localparam int ADDR_W   = $clog2(MAX_BYTES),
   localparam int LEN_W    = $clog2(MAX_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sof,
   input  logic              wr_eof,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              commit,
   output logic [LEN_W-1:0]  commit_len,
   output logic              commit_trunc
);
   logic [DATA_W-1:0] mem [MAX_BYTES];
   logic [LEN_W-1:0]  cnt;
   logic              open_q;
   logic              over_q;
   logic              room;
   logic              wen;
   logic [ADDR_W-1:0] waddr;

   always_comb begin
      room         = cnt < LEN_W'(MAX_BYTES);
      wen          = wr_en & (wr_sof | (open_q & room));
      waddr        = wr_sof ? '0 : ADDR_W'(cnt);
      commit       = wr_en & wr_eof & (wr_sof | open_q);
      commit_len   = wr_sof ? LEN_W'(1) : (room ? cnt + LEN_W'(1) : cnt);
      commit_trunc = ~wr_sof & (over_q | ~room);
   end

   always_ff @(posedge clk) begin
      if (wen) mem[waddr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         open_q <= 1'b0;
         over_q <= 1'b0;
      end else if (wr_en) begin
         if (wr_sof) begin
            cnt    <= LEN_W'(1);
            over_q <= 1'b0;
            open_q <= ~wr_eof;
         end else if (open_q) begin
            if (room) cnt <= cnt + LEN_W'(1);
            else      over_q <= 1'b1;
            if (wr_eof) open_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/eth_tx_replay_ctrl.sv
module eth_tx_replay_ctrl
   import eth_tx_replay_pkg::*;
#(
   parameter int MAX_BYTES      = 1518,
   parameter bit HALF_DUPLEX_EN = 1'b1,
   localparam int ADDR_W        = $clog2(MAX_BYTES),
   localparam int LEN_W         = $clog2(MAX_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              full_duplex,
   input  logic              commit,
   input  logic [LEN_W-1:0]  commit_len,
   input  logic              commit_trunc,
   input  logic              mac_ack,
   input  logic              mac_collision,
   input  logic              mac_retransmit,
   output logic [ADDR_W-1:0] rd_ptr,
   output logic              idle,
   output logic              armed,
   output logic              busy,
   output logic              sent_pulse,
   output logic              drop_pulse,
   output logic              trunc_pulse
);
   txs_e             state;
   logic [LEN_W-1:0] len_q;
   logic             col_eff;
   logic             rtx_eff;
   logic             at_last;

   generate
      if (HALF_DUPLEX_EN) begin : g_hdx
         assign col_eff = mac_collision & ~full_duplex;
         assign rtx_eff = mac_retransmit;
      end else begin : g_fdx_only
         logic unused_in;
         assign unused_in = mac_collision ^ mac_retransmit ^ full_duplex;
         assign col_eff   = 1'b0;
         assign rtx_eff   = 1'b0;
      end
   endgenerate

   assign at_last = LEN_W'(rd_ptr) == (len_q - LEN_W'(1));
   assign idle    = state == TXS_FILL;
   assign armed   = state == TXS_ARM;
   assign busy    = state != TXS_FILL;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= TXS_FILL;
         rd_ptr      <= '0;
         len_q       <= '0;
         sent_pulse  <= 1'b0;
         drop_pulse  <= 1'b0;
         trunc_pulse <= 1'b0;
      end else begin
         sent_pulse  <= 1'b0;
         drop_pulse  <= 1'b0;
         trunc_pulse <= 1'b0;
         unique case (state)
            TXS_FILL: begin
               if (commit) begin
                  len_q       <= commit_len;
                  trunc_pulse <= commit_trunc;
                  rd_ptr      <= '0;
                  state       <= TXS_ARM;
               end
            end
            TXS_ARM, TXS_STREAM: begin
               if (col_eff) begin
                  rd_ptr <= '0;
                  if (rtx_eff) begin
                     state <= TXS_ARM;
                  end else begin
                     state      <= TXS_FILL;
                     drop_pulse <= 1'b1;
                  end
               end else if (state == TXS_ARM) begin
                  if (mac_ack) begin
                     if (at_last) begin
                        state      <= TXS_FILL;
                        sent_pulse <= 1'b1;
                     end else begin
                        rd_ptr <= rd_ptr + ADDR_W'(1);
                        state  <= TXS_STREAM;
                     end
                  end
               end else if (at_last) begin
                  state      <= TXS_FILL;
                  sent_pulse <= 1'b1;
               end else begin
                  rd_ptr <= rd_ptr + ADDR_W'(1);
               end
            end
            default: state <= TXS_FILL;
         endcase
      end
   end
endmodule

// File: rtl/eth_tx_replay_adapter.sv
module eth_tx_replay_adapter #(
   parameter int DATA_W         = 8,
   parameter int MAX_BYTES      = 1518,
   parameter bit HALF_DUPLEX_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              full_duplex,
   input  logic [DATA_W-1:0] src_data,
   input  logic              src_wr,
   input  logic              src_sof,
   input  logic              src_eof,
   output logic              src_ready,
   output logic [DATA_W-1:0] mac_data,
   output logic              mac_valid,
   input  logic              mac_ack,
   input  logic              mac_collision,
   input  logic              mac_retransmit,
   output logic              frame_sent,
   output logic              frame_dropped,
   output logic              frame_truncated
);
   localparam int ADDR_W = $clog2(MAX_BYTES);
   localparam int LEN_W  = $clog2(MAX_BYTES + 1);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (MAX_BYTES < 2) begin : g_bad_depth
         $error("MAX_BYTES must be at least 2");
      end
   endgenerate

   logic              commit;
   logic [LEN_W-1:0]  commit_len;
   logic              commit_trunc;
   logic [ADDR_W-1:0] rd_ptr;
   logic              idle;
   logic              armed;
   logic              busy;

   eth_tx_frame_store #(
      .DATA_W   (DATA_W),
      .MAX_BYTES(MAX_BYTES)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (src_wr & idle),
      .wr_sof      (src_sof),
      .wr_eof      (src_eof),
      .wr_data     (src_data),
      .rd_addr     (rd_ptr),
      .rd_data     (mac_data),
      .commit      (commit),
      .commit_len  (commit_len),
      .commit_trunc(commit_trunc)
   );

   eth_tx_replay_ctrl #(
      .MAX_BYTES     (MAX_BYTES),
      .HALF_DUPLEX_EN(HALF_DUPLEX_EN)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .full_duplex   (full_duplex),
      .commit        (commit),
      .commit_len    (commit_len),
      .commit_trunc  (commit_trunc),
      .mac_ack       (mac_ack),
      .mac_collision (mac_collision),
      .mac_retransmit(mac_retransmit),
      .rd_ptr        (rd_ptr),
      .idle          (idle),
      .armed         (armed),
      .busy          (busy),
      .sent_pulse    (frame_sent),
      .drop_pulse    (frame_dropped),
      .trunc_pulse   (frame_truncated)
   );

   assign src_ready = idle;
   assign mac_valid = busy;
endmodule

// File: rtl/eth_tx_replay_chk.sv
module eth_tx_replay_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              full_duplex,
   input logic              src_ready,
   input logic [DATA_W-1:0] mac_data,
   input logic              mac_valid,
   input logic              mac_ack,
   input logic              mac_collision,
   input logic              mac_retransmit,
   input logic              frame_sent,
   input logic              frame_dropped,
   input logic              armed
);
   // R3
   hold_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed && !mac_ack && !(mac_collision && !full_duplex) |=> mac_valid && $stable(mac_data));

   // R2
   one_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(src_ready && mac_valid));

   // R4
   sent_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_sent |-> !mac_valid && src_ready);

   // R5
   replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mac_valid && mac_collision && mac_retransmit && !full_duplex |=> armed && mac_valid);

   // R6
   drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mac_valid && mac_collision && !mac_retransmit && !full_duplex |=> frame_dropped && !mac_valid);

   // R7
   fdx_no_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_duplex && mac_valid && !armed && mac_collision |=> !armed && !frame_dropped);
endmodule

bind eth_tx_replay_adapter eth_tx_replay_chk #(.DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .full_duplex   (full_duplex),
   .src_ready     (src_ready),
   .mac_data      (mac_data),
   .mac_valid     (mac_valid),
   .mac_ack       (mac_ack),
   .mac_collision (mac_collision),
   .mac_retransmit(mac_retransmit),
   .frame_sent    (frame_sent),
   .frame_dropped (frame_dropped),
   .armed         (armed)
);

// File: tb/tb_eth_tx_replay_adapter.sv
`timescale 1ns/1ps
module tb_eth_tx_replay_adapter;
   localparam int MAXB = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       full_duplex = 1'b0;
   logic [7:0] src_data = '0;
   logic       src_wr = 1'b0, src_sof = 1'b0, src_eof = 1'b0;
   logic       src_ready;
   logic [7:0] mac_data;
   logic       mac_valid;
   logic       mac_ack = 1'b0, mac_collision = 1'b0, mac_retransmit = 1'b0;
   logic       frame_sent, frame_dropped, frame_truncated;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   eth_tx_replay_adapter #(.DATA_W(8), .MAX_BYTES(MAXB), .HALF_DUPLEX_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex),
      .src_data(src_data), .src_wr(src_wr), .src_sof(src_sof), .src_eof(src_eof),
      .src_ready(src_ready), .mac_data(mac_data), .mac_valid(mac_valid),
      .mac_ack(mac_ack), .mac_collision(mac_collision), .mac_retransmit(mac_retransmit),
      .frame_sent(frame_sent), .frame_dropped(frame_dropped), .frame_truncated(frame_truncated)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] byte_of(input logic [7:0] base, input int i);
      return base + 8'(i * 7);
   endfunction

   task automatic wr_byte(input logic [7:0] d, input logic s, input logic e);
      src_data = d; src_sof = s; src_eof = e; src_wr = 1'b1;
      @(negedge clk);
      src_wr = 1'b0; src_sof = 1'b0; src_eof = 1'b0;
   endtask

   task automatic load(input int len, input logic [7:0] base);
      for (int i = 0; i < len; i++) wr_byte(byte_of(base, i), i == 0, i == len - 1);
   endtask

   // coll_k >= 1: raise collision+retransmit on that streamed byte (full duplex use)
   task automatic expect_stream(input int len, input logic [7:0] base, input int delay,
                                input string hold_tag, input int coll_k);
      for (int d = 0; d < delay; d++) begin
         chk(hold_tag, {mac_valid, mac_data}, {1'b1, byte_of(base, 0)});
         @(negedge clk);
      end
      chk("R2", {src_ready, mac_valid, mac_data}, {2'b01, byte_of(base, 0)});
      mac_ack = 1'b1;
      @(negedge clk);
      mac_ack = 1'b0;
      for (int k = 1; k < len; k++) begin
         chk("R4", {mac_valid, mac_data}, {1'b1, byte_of(base, k)});
         if (k == coll_k) begin mac_collision = 1'b1; mac_retransmit = 1'b1; end
         @(negedge clk);
         mac_collision = 1'b0; mac_retransmit = 1'b0;
      end
      chk("R4", {frame_sent, mac_valid, src_ready, frame_dropped}, 4'b1010);
   endtask

   task automatic coll_at(input int len, input logic [7:0] base, input int p, input bit rtx);
      load(len, base);
      if (p > 0) begin
         mac_ack = 1'b1;
         @(negedge clk);
         mac_ack = 1'b0;
         for (int k = 1; k < p; k++) @(negedge clk);
      end
      chk(rtx ? "R5" : "R6", {mac_valid, mac_data}, {1'b1, byte_of(base, p)});
      mac_collision = 1'b1; mac_retransmit = rtx;
      @(negedge clk);
      mac_collision = 1'b0; mac_retransmit = 1'b0;
      if (rtx) begin
         chk("R5", {mac_valid, src_ready, mac_data}, {2'b10, byte_of(base, 0)});
         expect_stream(len, base, 1, "R5", 0);
      end else begin
         chk("R6", {frame_dropped, mac_valid, src_ready}, 3'b101);
         @(negedge clk);
         chk("R6", {frame_dropped}, 1'b0);
      end
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", {src_ready, mac_valid, frame_sent, frame_dropped, frame_truncated}, 5'b10000);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {src_ready, mac_valid}, 2'b10);

      // sweep of lengths and acknowledge delays
      for (int len = 1; len <= MAXB; len++) begin
         for (int d = 0; d < 3; d++) begin
            load(len, 8'(len * 16 + d));
            chk("R8", {frame_truncated}, 1'b0);
            expect_stream(len, 8'(len * 16 + d), d, "R3", 0);
            @(negedge clk);
            chk("R4", {frame_sent}, 1'b0);
         end
      end

      // back-pressure: writes while a frame is held are ignored
      load(3, 8'h40);
      chk("R2", {src_ready}, 1'b0);
      wr_byte(8'hEE, 1'b1, 1'b1);
      chk("R2", {mac_valid, mac_data}, {1'b1, byte_of(8'h40, 0)});
      expect_stream(3, 8'h40, 0, "R3", 0);
      @(negedge clk);

      // collisions at every position, with and without replay
      for (int len = 2; len <= 4; len++)
         for (int p = 0; p < len; p++)
            for (int r = 0; r < 2; r++) begin
               coll_at(len, 8'(8'h80 + len * 8 + p), p, r[0]);
               @(negedge clk);
            end

      // full duplex: collisions ignored
      full_duplex = 1'b1;
      load(5, 8'h21);
      mac_collision = 1'b1; mac_retransmit = 1'b1;
      @(negedge clk);
      mac_collision = 1'b0; mac_retransmit = 1'b0;
      chk("R7", {mac_valid, frame_dropped, mac_data}, {2'b10, byte_of(8'h21, 0)});
      expect_stream(5, 8'h21, 0, "R7", 2);
      load(3, 8'h33);
      mac_ack = 1'b1;
      @(negedge clk);
      mac_ack = 1'b0;
      mac_collision = 1'b1;
      @(negedge clk);
      mac_collision = 1'b0;
      chk("R7", {mac_valid, frame_dropped, mac_data}, {2'b10, byte_of(8'h33, 2)});
      @(negedge clk);
      chk("R7", {frame_sent, frame_dropped}, 2'b10);
      full_duplex = 1'b0;

      // truncation
      load(MAXB + 2, 8'h55);
      chk("R8", {frame_truncated, mac_valid}, 2'b11);
      expect_stream(MAXB, 8'h55, 0, "R3", 0);
      @(negedge clk);

      // restart on sof, stray write without open frame
      wr_byte(8'h99, 1'b0, 1'b1);
      chk("R9", {src_ready, mac_valid}, 2'b10);
      wr_byte(8'h11, 1'b1, 1'b0);
      wr_byte(8'h12, 1'b0, 1'b0);
      wr_byte(8'h13, 1'b0, 1'b0);
      chk("R9", {src_ready, mac_valid}, 2'b10);
      load(4, 8'h66);
      expect_stream(4, 8'h66, 0, "R9", 0);
      @(negedge clk);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule